// File: doc/BRIEF.md
# Data-Ready Triggered SPI Sample Reader

This block is an SPI master that fetches one conversion result from a sigma-delta converter each time the converter reports a new sample. The converter is assumed to be in its continuous read mode, so a frame carries no command or address. Chip select drops, 32 serial clocks shift the result in on MISO, chip select rises, and the block presents the sample on a parallel bus with a one-cycle strobe. MOSI stays at a dummy level.

The serial clock is the system clock divided by an even ratio set on the `half_period` input. Received bits are packed into 16-bit words, so a frame is always a whole number of byte pairs. The first 24 bits form a signed two's complement sample and the trailing byte is dropped. A data-ready event that arrives while a frame is still running is not queued: it raises a one-cycle overrun pulse. That pulse is the sign that the frame is too long for the data rate. A frame has to end within half the data-ready period if the output data rate is to be doubled. The block also passes a host-controlled reset through to the converter.

Top module: `drdy_spi_reader`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `sclk` is 0, `sample_valid` and `overrun` are 0, `sample` is 0 and `adc_rst_n` is 0.
- R2: `drdy_n` is passed through two synchronising flops. Only a high-to-low transition starts a frame. `cs_n` falls on the third rising clock edge after `drdy_n` goes low. A level that stays low starts no further frames.
- R3: A frame has 32 SCLK periods. Each SCLK half period lasts max(`half_period`,1) system clocks. SCLK is low while idle and at the start of the frame (mode 0).
- R4: `mosi` is 0 at all times.
- R5: On the last falling SCLK edge, `cs_n` returns to 1 and `sample_valid` is 1 for exactly one cycle in that same cycle. `sample_valid` is never high at any other time.
- R6: MISO is sampled on each rising SCLK edge, most significant bit first. `sample` equals the first 24 received bits in two's complement: 0x7FFFFF is positive full scale, 0x800000 is negative full scale, 0xFFFFFF is -1 LSB and 0x000000 is midscale. The last 8 bits are discarded.
- R7: A `drdy_n` falling edge that is detected while `cs_n` is low raises `overrun` for one cycle, on the clock edge after detection. It does not start, stretch or alter the current frame.
- R8: `adc_rst_n` equals the inverse of `adc_rst_req`, registered one clock later.
- R9: `half_period` is captured when a frame starts. A change during a frame has no effect until the next frame.
- R10: `sample` holds its value between `sample_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_rst_req | input | 1 | Host request to hold the converter in reset |
| half_period | input | DIV_W (8) | SCLK half period in system clocks (0 acts as 1) |
| drdy_n | input | 1 | Active-low data-ready from the converter |
| miso | input | 1 | Serial data from the converter |
| adc_rst_n | output | 1 | Active-low reset to the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter (dummy, held 0) |
| sample | output | SAMPLE_W (24) | Last received signed sample |
| sample_valid | output | 1 | One-cycle strobe when a new sample is presented |
| overrun | output | 1 | One-cycle pulse when data-ready arrives mid-frame |

## Verification
A wrong bit counter or divider count shows up within one SCLK period: an SCLK edge lands in the wrong cycle, or `cs_n` rises early or late. The bench compares SCLK and `cs_n` on every clock, so such a fault fails on the first wrong edge. A fault in word packing or bit order changes `sample` only at the end of the frame. The full-scale, midscale and all-ones patterns expose a swapped word or byte. A lost busy indication shows up as a second frame, or as a missing `overrun` pulse, on the edge after a mid-frame data-ready event.

// File: rtl/drdy_rd_pkg.sv
package drdy_rd_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/drdy_edge_sync.sv
module drdy_edge_sync #(
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = din;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: IDLE_LVL, s2: IDLE_LVL, s3: IDLE_LVL};
        else        q <= d;
    end

    // active edge leaves the idle level
    assign evt = (q.s3 == IDLE_LVL) && (q.s2 != IDLE_LVL);
endmodule

// File: rtl/frame_word_packer.sv
module frame_word_packer
    import drdy_rd_pkg::*;
#(
    parameter int NWORDS   = 2,
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int BCNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [NWORDS-1:0][WORD_W-1:0] words;
        logic [WORD_W-1:0]             cur;
        logic [BCNT_W-1:0]             bcnt;
        logic [WIDX_W-1:0]             widx;
    } pk_t;

    pk_t q, d;
    logic [WORD_W-1:0] nxt_word;

    always_comb begin
        d        = q;
        nxt_word = {q.cur[WORD_W-2:0], bit_in};
        if (clr) begin
            d.cur  = '0;
            d.bcnt = '0;
            d.widx = '0;
        end else if (shift_en) begin
            d.cur = nxt_word;
            if (q.bcnt == BCNT_W'(WORD_W - 1)) begin
                d.words[q.widx] = nxt_word;
                d.widx          = q.widx + 1'b1;
                d.bcnt          = '0;
            end else begin
                d.bcnt = q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // first received word supplies the most significant bits
    for (genvar i = 0; i < SAMPLE_W; i++) begin : g_pick
        assign sample[SAMPLE_W-1-i] = q.words[i / WORD_W][WORD_W-1-(i % WORD_W)];
    end
endmodule

// File: rtl/drdy_spi_reader.sv
module drdy_spi_reader
    import drdy_rd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int FRAME_WORDS = 2,
    parameter int SAMPLE_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adc_rst_req,
    input  logic [DIV_W-1:0]    half_period,
    input  logic                drdy_n,
    input  logic                miso,
    output logic                adc_rst_n,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_valid,
    output logic                overrun
);
    localparam int FRAME_BITS = WORD_W * FRAME_WORDS;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        rd_state_e           st;
        logic                cs_n;
        logic                sclk;
        logic [DIV_W-1:0]    cnt;
        logic [DIV_W-1:0]    half;
        logic [BIT_W-1:0]    bitn;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
        logic                ovr;
        logic                arst_n;
    } rd_regs_t;

    localparam rd_regs_t RST_VAL = '{
        st: ST_IDLE, cs_n: 1'b1, sclk: 1'b0, cnt: '0, half: DIV_W'(1),
        bitn: '0, sample: '0, valid: 1'b0, ovr: 1'b0, arst_n: 1'b0
    };

    rd_regs_t q, d;
    logic drdy_evt;
    logic pk_clr, pk_shift;
    logic [SAMPLE_W-1:0] pk_sample;
    logic [DIV_W-1:0] half_eff;

    drdy_edge_sync #(.IDLE_LVL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (drdy_n),
        .evt   (drdy_evt)
    );

    frame_word_packer #(.NWORDS(FRAME_WORDS), .SAMPLE_W(SAMPLE_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pk_clr),
        .shift_en (pk_shift),
        .bit_in   (miso),
        .sample   (pk_sample)
    );

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        d.ovr    = 1'b0;
        d.arst_n = ~adc_rst_req;
        pk_clr   = 1'b0;
        pk_shift = 1'b0;
        half_eff = (half_period == '0) ? DIV_W'(1) : half_period;
        case (q.st)
            ST_IDLE: begin
                if (drdy_evt) begin
                    d.st   = ST_RUN;
                    d.cs_n = 1'b0;
                    d.sclk = 1'b0;
                    d.half = half_eff;
                    d.cnt  = half_eff - 1'b1;
                    d.bitn = '0;
                    pk_clr = 1'b1;
                end
            end
            ST_RUN: begin
                if (drdy_evt) d.ovr = 1'b1;
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!q.sclk) begin
                    d.sclk   = 1'b1;
                    d.cnt    = q.half - 1'b1;
                    pk_shift = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    d.cnt  = q.half - 1'b1;
                    if (q.bitn == LAST_BIT) begin
                        d.st     = ST_IDLE;
                        d.cs_n   = 1'b1;
                        d.valid  = 1'b1;
                        d.sample = pk_sample;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign adc_rst_n    = q.arst_n;
    assign cs_n         = q.cs_n;
    assign sclk         = q.sclk;
    assign mosi         = 1'b0;
    assign sample       = q.sample;
    assign sample_valid = q.valid;
    assign overrun      = q.ovr;
endmodule

// File: rtl/drdy_spi_reader_chk.sv
module drdy_spi_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic adc_rst_req,
    input logic adc_rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sample_valid,
    input logic overrun
);
    // R3
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R5
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (cs_n && $past(!cs_n)));

    // R5
    cs_rise_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sample_valid);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7
    overrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(!cs_n));

    // R8
    adc_rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (adc_rst_n == !$past(adc_rst_req)));
endmodule

bind drdy_spi_reader drdy_spi_reader_chk u_chk (.*);

// File: tb/drdy_spi_reader_tb.sv
module drdy_spi_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_rst_req = 1'b0;
    logic [7:0]  half_period = 8'd1;
    logic        drdy_n = 1'b1;
    logic        miso = 1'b0;
    logic        adc_rst_n, cs_n, sclk, mosi, sample_valid, overrun;
    logic [23:0] sample;

    logic [31:0] adc_word = 32'h0;
    int n_chk = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_ovr = 0;
    bit running = 1'b0;

    always #4 clk = ~clk;

    drdy_spi_reader u_dut (
        .clk(clk), .rst_n(rst_n), .adc_rst_req(adc_rst_req),
        .half_period(half_period), .drdy_n(drdy_n), .miso(miso),
        .adc_rst_n(adc_rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .sample(sample), .sample_valid(sample_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          dq[$];
    bit          m_busy;
    int          m_pos, m_h;
    logic [31:0] m_word;
    logic        e_cs = 1'b1, e_sclk = 1'b0, e_valid = 1'b0, e_ovr = 1'b0, e_arst = 1'b0;
    logic [23:0] e_sample = 24'h0;

    always @(posedge clk) begin
        bit ev;
        if (!rst_n) begin
            m_busy = 1'b0; e_cs = 1'b1; e_sclk = 1'b0; e_valid = 1'b0;
            e_ovr = 1'b0; e_arst = 1'b0; e_sample = 24'h0;
            dq = '{1'b1, 1'b1, 1'b1};
        end else begin
            ev = (dq[$-2] == 1'b1) && (dq[$-1] == 1'b0);
            e_valid = 1'b0;
            e_ovr = 1'b0;
            e_arst = !adc_rst_req;
            if (m_busy) begin
                if (ev) e_ovr = 1'b1;
                m_pos++;
                if (m_pos == 64 * m_h) begin
                    m_busy = 1'b0; e_cs = 1'b1; e_sclk = 1'b0; e_valid = 1'b1;
                    e_sample = m_word[31:8];
                end else begin
                    e_sclk = ((m_pos / m_h) % 2) == 1;
                end
            end else if (ev) begin
                m_busy = 1'b1; m_pos = 0;
                m_h = (half_period == 0) ? 1 : int'(half_period);
                m_word = adc_word;
                e_cs = 1'b0; e_sclk = 1'b0;
            end
            dq.push_back(drdy_n);
            if (dq.size() > 6) void'(dq.pop_front());
        end
    end

    // per-cycle comparison and converter model
    logic [31:0] adc_sh;
    int          adc_idx;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (running) begin
            chk(cs_n == e_cs, "R2", "cs_n", 32'(cs_n), 32'(e_cs));
            chk(sclk == e_sclk, "R3", "sclk", 32'(sclk), 32'(e_sclk));
            chk(mosi == 1'b0, "R4", "mosi", 32'(mosi), 32'h0);
            chk(sample_valid == e_valid, "R5", "sample_valid", 32'(sample_valid), 32'(e_valid));
            chk(overrun == e_ovr, "R7", "overrun", 32'(overrun), 32'(e_ovr));
            chk(adc_rst_n == e_arst, "R8", "adc_rst_n", 32'(adc_rst_n), 32'(e_arst));
            // R6 R10 sample value and hold
            chk(sample == e_sample, "R6", "sample", 32'(sample), 32'(e_sample));
            if (sample_valid) n_valid++;
            if (overrun) n_ovr++;
        end
        if (prev_cs && !cs_n) begin
            adc_sh = adc_word; adc_idx = 31; miso = adc_sh[31];
        end else if (!cs_n && prev_sclk && !sclk) begin
            adc_idx--;
            if (adc_idx >= 0) miso = adc_sh[adc_idx];
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    task automatic fire_drdy(input int low_cycles);
        @(negedge clk) drdy_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [7:0] h);
        int hh;
        hh = (h == 0) ? 1 : int'(h);
        adc_word = w;
        half_period = h;
        fire_drdy(6);
        repeat (64 * hh + 12) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk in reset", {30'h0, cs_n, sclk}, 32'h2);
        chk(sample_valid == 1'b0 && overrun == 1'b0, "R1", "strobes in reset", {30'h0, sample_valid, overrun}, 32'h0);
        chk(sample == 24'h0 && adc_rst_n == 1'b0, "R1", "sample/adc_rst_n in reset", {7'h0, adc_rst_n, sample}, 32'h0);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (4) @(negedge clk);

        // R6 full-scale and midscale codes under several dividers (R3)
        run_frame(32'h7FFFFF_A5, 8'd1);
        chk(sample == 24'h7FFFFF, "R6", "positive full scale", 32'(sample), 32'h7FFFFF);
        run_frame(32'h800000_3C, 8'd2);
        chk(sample == 24'h800000, "R6", "negative full scale", 32'(sample), 32'h800000);
        run_frame(32'hFFFFFF_FF, 8'd3);
        chk(sample == 24'hFFFFFF, "R6", "minus one LSB", 32'(sample), 32'hFFFFFF);
        // R3 divider value 0 behaves as 1
        run_frame(32'h000000_81, 8'd0);
        chk(sample == 24'h000000, "R6", "midscale, trailing byte dropped", 32'(sample), 32'h0);
        run_frame(32'h5A3C96_E1, 8'd2);

        // R7 data-ready during a frame
        v0 = n_ovr;
        adc_word = 32'h123456_78;
        half_period = 8'd2;
        fire_drdy(6);
        repeat (40) @(negedge clk);
        fire_drdy(6);
        repeat (150) @(negedge clk);
        chk(n_ovr == v0 + 1, "R7", "overrun pulse count", 32'(n_ovr), 32'(v0 + 1));
        chk(sample == 24'h123456, "R7", "frame unaffected", 32'(sample), 32'h123456);

        // R9 divider change mid-frame ignored
        adc_word = 32'hA1B2C3_D4;
        half_period = 8'd2;
        fire_drdy(6);
        repeat (30) @(negedge clk);
        half_period = 8'd5;
        repeat (140) @(negedge clk);
        chk(sample == 24'hA1B2C3, "R9", "sample after divider change", 32'(sample), 32'hA1B2C3);

        // R2 level held low starts one frame only
        v0 = n_valid;
        adc_word = 32'h0F0F0F_00;
        half_period = 8'd1;
        fire_drdy(300);
        repeat (20) @(negedge clk);
        chk(n_valid == v0 + 1, "R2", "single frame for held level", 32'(n_valid), 32'(v0 + 1));

        // R8 converter reset follows host request
        adc_rst_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_rst_n == 1'b0, "R8", "adc_rst_n asserted", 32'(adc_rst_n), 32'h0);
        adc_rst_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(adc_rst_n == 1'b1, "R8", "adc_rst_n released", 32'(adc_rst_n), 32'h1);

        // R10 sample held while idle
        repeat (50) @(negedge clk);
        chk(sample == 24'h0F0F0F, "R10", "sample held", 32'(sample), 32'h0F0F0F);

        finish_run();
    end
endmodule